// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether one memory access may proceed under a small set of physical protection entries. Each entry has a configuration byte and an address register. The block receives all of them, together with the access itself: the first byte address, the byte count minus one, the requested read/write/execute set and the privilege level. It also receives two security policy bits. It returns the permission set that applies to the access, plus a grant flag. It is purely combinational and stores nothing. It does not report faults and does not own the entry registers, so it can sit directly in a load/store or fetch path.

Every entry decodes its own address window with a range decoder. A priority selector then picks the lowest-numbered entry whose window holds the whole access. The resolver takes one of three decision paths:
- `PATH_CLASSIC`: a matching entry while lockdown is clear.
- `PATH_LOCKDOWN`: a matching entry while machine-mode lockdown is set. A 16-way table indexed by the entry's lock and permission bits supplies the permissions, with one table for machine mode and another for all other modes.
- `PATH_DEFAULT`: no entry matches. The two policy bits then decide the fallback.

The transitions between paths are pure functions of the current inputs: a match with lockdown clear, a match with lockdown set, or no match.

Top module: `pmp_access_check`

## Requirements
- R1: Each configuration byte encodes read in bit 0, write in bit 1, execute in bit 2, the match mode in bits 4:3 (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two) and lock in bit 7. An entry whose mode is off never matches. Permission vectors on the ports use bit 0 for read, bit 1 for write and bit 2 for execute.
- R2: In power-of-two mode, let a be the entry address shifted left by two with the two low bits set. The window runs from a AND (a+1) to a OR (a+1), inclusive. An address register of all ones covers the whole address space.
- R3: In top-of-range mode, the window runs from four times the previous entry's address up to four times this entry's address, excluding the upper bound. Entry 0 uses a lower bound of 0. The window is empty when the upper bound is not above the lower bound.
- R4: In four-byte mode, the window covers exactly the four bytes that start at four times the entry address.
- R5: An entry matches only when both the first byte and the last byte of the access lie inside its window. An access whose last byte passes the top of the address space matches no entry.
- R6: When several entries match, the lowest-numbered one alone sets the result.
- R7: With lockdown clear, a matching unlocked entry gives machine mode (privilege code 3) all of read, write and execute. A locked entry gives any mode only its own three permission bits. An unlocked entry also gives a mode other than machine mode only its own three bits.
- R8: With lockdown set, a match in machine mode is resolved through the index {L,R,W,X}:
  - indices 2, 3 and 14 give read and write;
  - 9 and 10 give execute;
  - 11 and 13 give read and execute;
  - 12 and 15 give read;
  - every other index gives nothing.
- R9: With lockdown set, a match in any other mode is resolved through the same index:
  - 7 gives all three;
  - 3 and 6 give read and write;
  - 5 gives read and execute;
  - 2, 4 and 15 give read;
  - 1, 10 and 11 give execute;
  - every other index gives nothing.
- R10: With no match and the whitelist bit set, nothing is allowed in any mode.
- R11: With no match, the whitelist bit clear and lockdown set, the result depends on the request. Machine mode is allowed read and write when the request does not include execute. Otherwise nothing is allowed.
- R12: With no match and both policy bits clear, machine mode is allowed everything and other modes nothing.
- R13: The grant output is high exactly when every requested bit is present in the allowed set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_addr | input | ADDR_W+2 | First byte address of the access |
| acc_len_m1 | input | LEN_W | Byte count of the access minus one |
| acc_req | input | 3 | Requested permissions (bit 0 read, bit 1 write, bit 2 execute) |
| priv_mode | input | 2 | Privilege level; 3 is machine mode |
| ent_cfg | input | 8*NUM_ENTRIES | Configuration bytes, entry i in bits 8i+7:8i |
| ent_addr | input | ADDR_W*NUM_ENTRIES | Address registers holding byte address divided by four, entry i in slice i |
| lockdown | input | 1 | Machine-mode lockdown policy bit |
| whitelist | input | 1 | Deny-by-default policy bit for unmatched accesses |
| allow_rwx | output | 3 | Allowed permission set |
| grant | output | 1 | Access permitted |

## Verification
A wrong window bound, or a wrong priority choice, shows up at once as a changed allowed set. This happens only at the addresses next to a window edge, where the access straddles a boundary or two entries overlap. A single wrong cell in a lockdown table is visible only for that lock/permission combination, in that mode class. Since no state is held, every fault appears in the same evaluation as the stimulus that exposes it. The sweeps therefore walk every byte address with every access length, and every table index against every request and mode.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    localparam int CFG_R_BIT = 0;
    localparam int CFG_W_BIT = 1;
    localparam int CFG_X_BIT = 2;
    localparam int CFG_L_BIT = 7;

    typedef enum logic [1:0] {
        WIN_OFF   = 2'd0,
        WIN_TOR   = 2'd1,
        WIN_FOUR  = 2'd2,
        WIN_POW2  = 2'd3
    } win_mode_e;

    typedef enum logic [1:0] {
        PATH_DEFAULT  = 2'd0,
        PATH_CLASSIC  = 2'd1,
        PATH_LOCKDOWN = 2'd2
    } decide_path_e;

    typedef logic [2:0] rwx_t;

endpackage

// File: rtl/pmpc_region_match.sv
module pmpc_region_match #(
    parameter int ADDR_W = 32,
    parameter int XW     = ADDR_W + 2
) (
    input  logic [7:0]        cfg,
    input  logic [ADDR_W-1:0] this_addr,
    input  logic [ADDR_W-1:0] prev_addr,
    input  logic [XW-1:0]     first_byte,
    input  logic [XW:0]       last_byte,
    output logic              hit
);
    import pmpc_pkg::*;

    win_mode_e   wmode;
    logic [XW:0] lo;
    logic [XW:0] hi;
    logic [XW:0] top_excl;
    logic [XW:0] pat;
    logic        empty;

    assign wmode = win_mode_e'(cfg[4:3]);

    always_comb begin
        lo       = '0;
        hi       = '0;
        top_excl = '0;
        pat      = '0;
        empty    = 1'b1;
        unique case (wmode)
            WIN_OFF: begin
                empty = 1'b1;
            end
            WIN_TOR: begin
                lo       = {1'b0, prev_addr, 2'b00};
                top_excl = {1'b0, this_addr, 2'b00};
                empty    = (top_excl <= lo);
                hi       = top_excl - 1'b1;
            end
            WIN_FOUR: begin
                lo    = {1'b0, this_addr, 2'b00};
                hi    = lo + 3;
                empty = 1'b0;
            end
            WIN_POW2: begin
                pat   = {1'b0, this_addr, 2'b11};
                lo    = pat & (pat + 1'b1);
                hi    = (pat | (pat + 1'b1)) & {1'b0, {XW{1'b1}}};
                empty = 1'b0;
            end
        endcase
    end

    assign hit = !empty && ({1'b0, first_byte} >= lo) && (last_byte <= hi);

endmodule

// File: rtl/pmpc_first_hit.sv
module pmpc_first_hit #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [NUM_ENTRIES-1:0] hits,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       sel_idx
);
    always_comb begin
        sel_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) sel_idx = IDX_W'(i);
        end
    end

    assign any_hit = |hits;

endmodule

// File: rtl/pmpc_perm_resolve.sv
module pmpc_perm_resolve (
    input  logic       any_hit,
    input  logic [7:0] sel_cfg,
    input  logic [2:0] req,
    input  logic [1:0] priv_mode,
    input  logic       lockdown,
    input  logic       whitelist,
    output logic [2:0] allow,
    output logic       grant
);
    import pmpc_pkg::*;

    decide_path_e path;
    logic         is_m;
    logic [3:0]   tidx;
    rwx_t         own_rwx;
    rwx_t         m_tab;
    rwx_t         u_tab;

    assign is_m    = (priv_mode == PRIV_MACHINE);
    assign own_rwx = {sel_cfg[CFG_X_BIT], sel_cfg[CFG_W_BIT], sel_cfg[CFG_R_BIT]};
    assign tidx    = {sel_cfg[CFG_L_BIT], sel_cfg[CFG_R_BIT],
                      sel_cfg[CFG_W_BIT], sel_cfg[CFG_X_BIT]};

    always_comb begin
        if (!any_hit)      path = PATH_DEFAULT;
        else if (lockdown) path = PATH_LOCKDOWN;
        else               path = PATH_CLASSIC;
    end

    // Machine-mode lockdown table, result as {X,W,R}
    always_comb begin
        unique case (tidx)
            4'd2, 4'd3, 4'd14: m_tab = 3'b011;
            4'd9, 4'd10:       m_tab = 3'b100;
            4'd11, 4'd13:      m_tab = 3'b101;
            4'd12, 4'd15:      m_tab = 3'b001;
            default:           m_tab = 3'b000;
        endcase
    end

    // Lower-privilege lockdown table, result as {X,W,R}
    always_comb begin
        unique case (tidx)
            4'd7:              u_tab = 3'b111;
            4'd3, 4'd6:        u_tab = 3'b011;
            4'd5:              u_tab = 3'b101;
            4'd2, 4'd4, 4'd15: u_tab = 3'b001;
            4'd1, 4'd10, 4'd11: u_tab = 3'b100;
            default:           u_tab = 3'b000;
        endcase
    end

    always_comb begin
        allow = 3'b000;
        unique case (path)
            PATH_CLASSIC: begin
                if (is_m && !sel_cfg[CFG_L_BIT]) allow = 3'b111;
                else                             allow = own_rwx;
            end
            PATH_LOCKDOWN: begin
                allow = is_m ? m_tab : u_tab;
            end
            PATH_DEFAULT: begin
                if (whitelist)     allow = 3'b000;
                else if (lockdown) allow = (is_m && !req[2]) ? 3'b011 : 3'b000;
                else               allow = is_m ? 3'b111 : 3'b000;
            end
            default: allow = 3'b000;
        endcase
    end

    assign grant = ((req & ~allow) == 3'b000);

endmodule

// File: rtl/pmp_access_check.sv
module pmp_access_check #(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 4
) (
    input  logic [ADDR_W+1:0]             acc_addr,
    input  logic [LEN_W-1:0]              acc_len_m1,
    input  logic [2:0]                    acc_req,
    input  logic [1:0]                    priv_mode,
    input  logic [8*NUM_ENTRIES-1:0]      ent_cfg,
    input  logic [ADDR_W*NUM_ENTRIES-1:0] ent_addr,
    input  logic                          lockdown,
    input  logic                          whitelist,
    output logic [2:0]                    allow_rwx,
    output logic                          grant
);
    localparam int XW    = ADDR_W + 2;
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic [XW:0]             last_byte;
    logic [NUM_ENTRIES-1:0]  hits;
    logic                    any_hit;
    logic [IDX_W-1:0]        sel_idx;
    logic [7:0]              sel_cfg;

    assign last_byte = {1'b0, acc_addr} + {{(XW+1-LEN_W){1'b0}}, acc_len_m1};

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_win
        logic [ADDR_W-1:0] prev_a;
        if (g == 0) begin : g_base
            assign prev_a = '0;
        end else begin : g_chain
            assign prev_a = ent_addr[(g-1)*ADDR_W +: ADDR_W];
        end
        pmpc_region_match #(.ADDR_W(ADDR_W), .XW(XW)) u_win (
            .cfg        (ent_cfg[g*8 +: 8]),
            .this_addr  (ent_addr[g*ADDR_W +: ADDR_W]),
            .prev_addr  (prev_a),
            .first_byte (acc_addr),
            .last_byte  (last_byte),
            .hit        (hits[g])
        );
    end

    pmpc_first_hit #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .hits    (hits),
        .any_hit (any_hit),
        .sel_idx (sel_idx)
    );

    always_comb begin
        sel_cfg = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (sel_idx == IDX_W'(i)) sel_cfg = ent_cfg[i*8 +: 8];
        end
    end

    pmpc_perm_resolve u_res (
        .any_hit   (any_hit),
        .sel_cfg   (sel_cfg),
        .req       (acc_req),
        .priv_mode (priv_mode),
        .lockdown  (lockdown),
        .whitelist (whitelist),
        .allow     (allow_rwx),
        .grant     (grant)
    );

endmodule

// File: rtl/pmpc_checker.sv
module pmpc_checker (
    input logic       any_hit,
    input logic [7:0] sel_cfg,
    input logic [2:0] acc_req,
    input logic [1:0] priv_mode,
    input logic       lockdown,
    input logic       whitelist,
    input logic [2:0] allow_rwx,
    input logic       grant
);
    always_comb begin
        // R13
        grant_subset_chk: assert (grant == ((acc_req & allow_rwx) == acc_req))
            else $error("grant disagrees with allowed set");
        // R10
        deny_all_chk: assert (!( !any_hit && whitelist) || allow_rwx == 3'b000)
            else $error("whitelist default allowed something");
        // R12
        m_open_default_chk: assert (!(!any_hit && !whitelist && !lockdown && priv_mode == 2'b11)
                                    || allow_rwx == 3'b111)
            else $error("machine default not fully open");
        // R7
        classic_bound_chk: assert (!(any_hit && !lockdown && (priv_mode != 2'b11 || sel_cfg[7]))
                                   || (allow_rwx & ~sel_cfg[2:0]) == 3'b000)
            else $error("classic path exceeded entry bits");
        // R8
        m_lock_cap_chk: assert (!(any_hit && lockdown && priv_mode == 2'b11)
                                || allow_rwx != 3'b111)
            else $error("machine mode got all rights under lockdown");
        // R11
        lock_default_chk: assert (!(!any_hit && !whitelist && lockdown)
                                  || allow_rwx[2] == 1'b0)
            else $error("lockdown default allowed execute");
    end
endmodule

bind pmp_access_check pmpc_checker u_chk (
    .any_hit   (any_hit),
    .sel_cfg   (sel_cfg),
    .acc_req   (acc_req),
    .priv_mode (priv_mode),
    .lockdown  (lockdown),
    .whitelist (whitelist),
    .allow_rwx (allow_rwx),
    .grant     (grant)
);

// File: tb/test_pmp_access_check.sv
module test_pmp_access_check;
    localparam int N  = 4;
    localparam int AW = 6;
    localparam int XW = AW + 2;
    localparam int LW = 2;

    localparam logic [15:0] MT_R = 16'hF80C, MT_W = 16'h400C, MT_X = 16'h2E00;
    localparam logic [15:0] UT_R = 16'h80FC, UT_W = 16'h00C8, UT_X = 16'h0CA2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [XW-1:0]   acc_addr;
    logic [LW-1:0]   acc_len_m1;
    logic [2:0]      acc_req;
    logic [1:0]      priv_mode;
    logic [8*N-1:0]  ent_cfg;
    logic [AW*N-1:0] ent_addr;
    logic            lockdown, whitelist;
    logic [2:0]      allow_rwx;
    logic            grant;

    logic [7:0]    cfg_m [N];
    logic [AW-1:0] adr_m [N];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_cfg[i*8 +: 8]    = cfg_m[i];
            ent_addr[i*AW +: AW] = adr_m[i];
        end
    end

    pmp_access_check #(.NUM_ENTRIES(N), .ADDR_W(AW), .LEN_W(LW)) i_pmp_access_check (
        .acc_addr(acc_addr), .acc_len_m1(acc_len_m1), .acc_req(acc_req),
        .priv_mode(priv_mode), .ent_cfg(ent_cfg), .ent_addr(ent_addr),
        .lockdown(lockdown), .whitelist(whitelist),
        .allow_rwx(allow_rwx), .grant(grant)
    );

    function automatic bit in_win(int e, int first, int last);
        int md, lo, hiex, k, v;
        md = int'(cfg_m[e][4:3]);
        v  = int'(adr_m[e]);
        if (md == 0) return 1'b0;                       // R1 off
        if (md == 1) begin                              // R3
            lo   = (e == 0) ? 0 : int'(adr_m[e-1]) * 4;
            hiex = v * 4;
            return (first >= lo) && (last < hiex);
        end
        if (md == 2) return (first >= v*4) && (last <= v*4 + 3);   // R4
        k = 0;                                          // R2
        while (k < AW && ((v >> k) & 1) == 1) k++;
        if (k == AW) return last < (1 << XW);
        lo   = (v & ~((1 << (k+1)) - 1)) * 4;
        hiex = lo + (8 << k);
        return (first >= lo) && (last < hiex);
    endfunction

    task automatic model(input int a, input int len, input int req, input int md,
                         input bit mml, input bit mmwp,
                         output logic [2:0] exp_allow, output string tag);
        int hit_e, idx;
        logic [7:0] c;
        hit_e = -1;
        for (int e = 0; e < N; e++)                     // R5 R6
            if (hit_e < 0 && in_win(e, a, a + len)) hit_e = e;
        if (hit_e >= 0) begin
            c   = cfg_m[hit_e];
            idx = {c[7], c[0], c[1], c[2]};
            if (!mml) begin
                exp_allow = (md == 3 && !c[7]) ? 3'b111 : c[2:0];
                tag = "R7";
            end else if (md == 3) begin
                exp_allow = {MT_X[idx], MT_W[idx], MT_R[idx]};
                tag = "R8";
            end else begin
                exp_allow = {UT_X[idx], UT_W[idx], UT_R[idx]};
                tag = "R9";
            end
        end else if (mmwp) begin
            exp_allow = 3'b000; tag = "R10";
        end else if (mml) begin
            exp_allow = (md == 3 && (req & 4) == 0) ? 3'b011 : 3'b000; tag = "R11";
        end else begin
            exp_allow = (md == 3) ? 3'b111 : 3'b000; tag = "R12";
        end
    endtask

    task automatic one(input string scen, input int a, input int len, input int req,
                       input int md, input bit mml, input bit mmwp);
        logic [2:0] ea;
        logic eg;
        string tag;
        acc_addr = XW'(a); acc_len_m1 = LW'(len); acc_req = 3'(req);
        priv_mode = 2'(md); lockdown = mml; whitelist = mmwp;
        #1;
        model(a, len, req, md, mml, mmwp, ea, tag);
        eg = ((3'(req) & ~ea) == 3'b000);
        checks++;
        if (allow_rwx !== ea) begin
            fails++;
            $display("FAIL %s %s allow addr=%0d len=%0d req=%0d mode=%0d mml=%0d mmwp=%0d got=%b exp=%b",
                     tag, scen, a, len+1, req, md, mml, mmwp, allow_rwx, ea);
        end
        checks++;
        if (grant !== eg) begin
            fails++;
            $display("FAIL R13 %s grant addr=%0d req=%0d got=%b exp=%b", scen, a, req, grant, eg);
        end
    endtask

    task automatic sweep(input string scen);
        for (int a = 0; a < 256; a++)
            for (int l = 0; l < 4; l++)
                for (int r = 0; r < 8; r++)
                    for (int m = 0; m < 4; m += 3)
                        for (int s = 0; s < 4; s++)
                            one(scen, a, l, r, m, s[0], s[1]);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin cfg_m[i] = 8'h00; adr_m[i] = '0; end
        // Idle state: all entries off, M-mode open (R1, R12), U-mode closed
        one("idle", 0, 0, 7, 3, 1'b0, 1'b0);
        one("idle", 17, 1, 1, 0, 1'b0, 1'b0);

        // R1 R3 R4 R5 R6: four-byte inside TOR, locked power-of-two, one off
        cfg_m[0] = 8'h11; adr_m[0] = 6'h05;   // four-byte, R
        cfg_m[1] = 8'h0B; adr_m[1] = 6'h10;   // TOR 20..63, RW
        cfg_m[2] = 8'h9C; adr_m[2] = 6'h23;   // power-of-two 128..159, X, locked
        cfg_m[3] = 8'h07; adr_m[3] = 6'h3F;   // off
        sweep("overlap");

        // R2 R3: empty TOR at entry 0, whole-space window, small window behind it
        cfg_m[0] = 8'h0F; adr_m[0] = 6'h00;   // TOR empty
        cfg_m[1] = 8'h9B; adr_m[1] = 6'h1B;   // power-of-two 96..127, locked RW
        cfg_m[2] = 8'h0D; adr_m[2] = 6'h18;   // TOR 108..95 empty
        cfg_m[3] = 8'h1D; adr_m[3] = 6'h3F;   // whole space, RX
        sweep("whole");

        // R4 R5: four-byte at the top of the space, access passing the end
        cfg_m[0] = 8'h08; adr_m[0] = 6'h08;   // TOR 0..31, no rights
        cfg_m[1] = 8'h8F; adr_m[1] = 6'h0C;   // TOR 32..47 locked RWX
        cfg_m[2] = 8'h17; adr_m[2] = 6'h3F;   // four-byte 252..255 RWX
        cfg_m[3] = 8'h1A; adr_m[3] = 6'h2B;   // power-of-two 160..191, W
        sweep("top");

        // R8 R9: every {L,R,W,X} index against every request and mode
        cfg_m[1] = 8'h00; cfg_m[2] = 8'h00; cfg_m[3] = 8'h00;
        adr_m[0] = 6'h3F;
        for (int t = 0; t < 16; t++) begin
            cfg_m[0] = {t[3], 2'b00, 2'b11, t[1], t[0], t[2]};
            for (int r = 0; r < 8; r++)
                for (int m = 0; m < 4; m++)
                    for (int s = 0; s < 4; s++)
                        one("table", 64, 0, r, m, s[0], s[1]);
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule